// File: doc/BRIEF.md
# Radio Idle Power-Mode Controller

This block decides which supply and clock resources of a low-power radio transceiver are switched on while the radio is not transmitting or receiving. It watches a shutdown pin, a software reset strobe and writes to an operating-mode control byte. Each idle sub-mode is requested by its own control bit, and the bits add enables on top of each other. The controller drives enable lines for the low-power regulator, the wake-up timer, the low-battery detector, the temperature sensor, the crystal oscillator, the crystal output buffer and the PLL. It also reports whether the register file holds valid contents and whether serial-port access is allowed.

Releasing the shutdown pin starts a power-on sequence of a fixed number of clock cycles, after which the crystal-on idle mode is selected. The deep low-current modes are held off while an interrupt is latched, until the interrupt status is read. A buffer-override bit from the crystal control register keeps the controller in the crystal-on mode until it is cleared. A 3-bit status output names the current state.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: While `shdn_i` is sampled high, the next state is SHUTDOWN. In SHUTDOWN every enable, `regs_valid_o` and `spi_ok_o` are 0, and mode writes and software resets have no effect.
- R2: When `shdn_i` is sampled low while in SHUTDOWN, the state is POR for exactly `POR_CYCLES` cycles. During POR all enables and `regs_valid_o` are 0, `spi_ok_o` is 1, and mode writes are ignored. Leaving reset also enters POR.
- R3: At the end of POR, and on a `swrst_i` strobe in any idle mode, the stored mode becomes crystal-on only (READY). `swrst_i` takes precedence over a mode write in the same cycle.
- R4: The mode byte bits are: bit 6 wake-up timer, bit 5 low-battery detector, bit 3 temperature sensor, bit 1 PLL-on, bit 0 crystal-on. Bits 7, 4 and 2 are ignored. The priority order is TUNE > READY > SENSOR > SLEEP > STANDBY.
- R5: A mode byte of 0x00 gives STANDBY, in which only `en_ldo_o` is 1 among the enables. `regs_valid_o` and `spi_ok_o` are 1.
- R6: Bit 6 alone gives SLEEP (regulator and wake-up timer). Bit 5 or bit 3 gives SENSOR. In every idle state, `en_wut_o`, `en_lbd_o` and `en_tmp_o` follow bits 6, 5 and 3.
- R7: In READY and TUNE, `en_xtal_o` is 1, and `en_xbuf_o` equals `en_xtal_o` and not `buf_ovr_i`.
- R8: Bit 1 gives TUNE, with `en_pll_o` and `en_xtal_o` both 1 even when bit 0 is 0.
- R9: An interrupt flag is set at the end of POR and whenever `irq_pend_i` is sampled high. It is cleared by `irq_stat_rd_i`, and the read wins if both are sampled together. While the flag is set, a STANDBY, SLEEP or SENSOR target is replaced by READY.
- R10: While in READY with `buf_ovr_i` high, a target below READY is held at READY.
- R11: `mode_o` encodes the states as SHUTDOWN=0, POR=1, STANDBY=2, SLEEP=3, SENSOR=4, READY=5, TUNE=6. Every input takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, enters POR |
| shdn_i | input | 1 | Shutdown pin, high forces SHUTDOWN |
| swrst_i | input | 1 | Software reset strobe |
| mode_we_i | input | 1 | Mode byte write strobe |
| mode_wdata_i | input | 8 | Mode byte write data |
| irq_pend_i | input | 1 | Interrupt pending flag |
| irq_stat_rd_i | input | 1 | Interrupt status read strobe |
| buf_ovr_i | input | 1 | Crystal buffer override bit |
| en_ldo_o | output | 1 | Low-power regulator enable |
| en_wut_o | output | 1 | Wake-up timer enable |
| en_lbd_o | output | 1 | Low-battery detector enable |
| en_tmp_o | output | 1 | Temperature sensor enable |
| en_xtal_o | output | 1 | Crystal oscillator enable |
| en_xbuf_o | output | 1 | Crystal buffer enable |
| en_pll_o | output | 1 | PLL enable |
| regs_valid_o | output | 1 | Register file contents valid |
| spi_ok_o | output | 1 | Serial access permitted |
| mode_o | output | 3 | Current state code |

## Verification
The hardest situations to reach are the ones where two hold-off conditions overlap. One is an interrupt latched in the same cycle as a write that targets a deep mode. Another is a status read arriving together with a new pending pulse. A third is the buffer override being released while the interrupt flag still holds READY. Directed sequences set up each of these explicitly. Long random runs then mix sparse shutdown pulses, software resets, pending pulses and reads with random mode bytes, so that the hold-off flags are often set while a write is in flight. A cycle model in the bench, built from the requirements, predicts every output on every cycle.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;

    typedef enum logic [2:0] {
        PM_SHDN  = 3'd0,
        PM_POR   = 3'd1,
        PM_STBY  = 3'd2,
        PM_SLEEP = 3'd3,
        PM_SENSE = 3'd4,
        PM_READY = 3'd5,
        PM_TUNE  = 3'd6
    } pm_state_e;

    localparam int BIT_WUT  = 6;
    localparam int BIT_LBD  = 5;
    localparam int BIT_TMP  = 3;
    localparam int BIT_PLL  = 1;
    localparam int BIT_XTON = 0;

    typedef struct packed {
        logic wut;
        logic lbd;
        logic tmp;
        logic pll;
        logic xton;
    } mode_bits_t;

    localparam mode_bits_t MODE_DEFAULT = '{wut: 1'b0, lbd: 1'b0, tmp: 1'b0, pll: 1'b0, xton: 1'b1};

endpackage

// File: rtl/pm_target_decode.sv
module pm_target_decode
    import pm_ctrl_pkg::*;
(
    input  mode_bits_t mode,
    input  logic       irq_hold,
    output pm_state_e  target
);
    pm_state_e low_target;

    // R4: priority TUNE > READY > SENSOR > SLEEP > STANDBY
    always_comb begin
        if (mode.lbd || mode.tmp) begin
            low_target = PM_SENSE;
        end else if (mode.wut) begin
            low_target = PM_SLEEP;
        end else begin
            low_target = PM_STBY;
        end

        if (mode.pll) begin
            target = PM_TUNE;
        end else if (mode.xton || irq_hold) begin
            target = PM_READY;   // R9: latched interrupt keeps the crystal mode
        end else begin
            target = low_target;
        end
    end
endmodule

// File: rtl/pm_enable_map.sv
module pm_enable_map
    import pm_ctrl_pkg::*;
(
    input  pm_state_e  state,
    input  mode_bits_t mode,
    input  logic       buf_ovr,
    output logic       en_ldo,
    output logic       en_wut,
    output logic       en_lbd,
    output logic       en_tmp,
    output logic       en_xtal,
    output logic       en_xbuf,
    output logic       en_pll,
    output logic       regs_valid,
    output logic       spi_ok
);
    logic running;
    logic xtal_on;

    always_comb begin
        running    = (state != PM_SHDN) && (state != PM_POR);
        xtal_on    = (state == PM_READY) || (state == PM_TUNE);   // R8
        en_ldo     = running;
        en_wut     = running && mode.wut;     // R6
        en_lbd     = running && mode.lbd;
        en_tmp     = running && mode.tmp;
        en_xtal    = xtal_on;
        en_xbuf    = xtal_on && !buf_ovr;     // R7
        en_pll     = (state == PM_TUNE);
        regs_valid = running;
        spi_ok     = (state != PM_SHDN);      // R1
    end
endmodule

// File: rtl/radio_pwr_ctrl.sv
module radio_pwr_ctrl
    import pm_ctrl_pkg::*;
#(
    parameter int POR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_i,
    input  logic       swrst_i,
    input  logic       mode_we_i,
    input  logic [7:0] mode_wdata_i,
    input  logic       irq_pend_i,
    input  logic       irq_stat_rd_i,
    input  logic       buf_ovr_i,
    output logic       en_ldo_o,
    output logic       en_wut_o,
    output logic       en_lbd_o,
    output logic       en_tmp_o,
    output logic       en_xtal_o,
    output logic       en_xbuf_o,
    output logic       en_pll_o,
    output logic       regs_valid_o,
    output logic       spi_ok_o,
    output logic [2:0] mode_o
);
    localparam int CNT_W = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(POR_CYCLES - 1);

    typedef struct packed {
        pm_state_e        state;
        mode_bits_t       mode;
        logic [CNT_W-1:0] cnt;
        logic             irq_hold;
        logic             shdn;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        state: PM_POR, mode: MODE_DEFAULT, cnt: CNT_LOAD, irq_hold: 1'b1, shdn: 1'b0
    };

    ctrl_t      ctrl_d, ctrl_q;
    mode_bits_t wr_bits;
    mode_bits_t mode_nxt_d;
    pm_state_e  target;
    logic       keep_ready;
    logic       unused_rsvd;

    // R4: reserved bits of the write byte carry no function
    assign unused_rsvd = ^{mode_wdata_i[7], mode_wdata_i[4], mode_wdata_i[2]};

    assign wr_bits = '{
        wut:  mode_wdata_i[BIT_WUT],
        lbd:  mode_wdata_i[BIT_LBD],
        tmp:  mode_wdata_i[BIT_TMP],
        pll:  mode_wdata_i[BIT_PLL],
        xton: mode_wdata_i[BIT_XTON]
    };

    // R3: software reset beats a same-cycle write
    assign mode_nxt_d = swrst_i   ? MODE_DEFAULT :
                        mode_we_i ? wr_bits      : ctrl_q.mode;

    pm_target_decode u_decode (
        .mode     (mode_nxt_d),
        .irq_hold (ctrl_q.irq_hold),
        .target   (target)
    );

    // R10: buffer override pins the controller in READY
    assign keep_ready = (ctrl_q.state == PM_READY) && buf_ovr_i && (target < PM_READY);

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.shdn = shdn_i;
        if (shdn_i) begin
            ctrl_d.state = PM_SHDN;                       // R1
        end else if (ctrl_q.shdn || ctrl_q.state == PM_SHDN) begin
            ctrl_d.state = PM_POR;                        // R2
            ctrl_d.cnt   = CNT_LOAD;
        end else if (ctrl_q.state == PM_POR) begin
            if (ctrl_q.cnt == '0) begin
                ctrl_d.state    = PM_READY;               // R3
                ctrl_d.mode     = MODE_DEFAULT;
                ctrl_d.irq_hold = 1'b1;                   // R9
            end else begin
                ctrl_d.cnt = ctrl_q.cnt - 1'b1;
            end
        end else begin
            ctrl_d.mode  = mode_nxt_d;
            ctrl_d.state = keep_ready ? PM_READY : target;
            if (irq_stat_rd_i) begin
                ctrl_d.irq_hold = 1'b0;
            end else if (irq_pend_i) begin
                ctrl_d.irq_hold = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    pm_enable_map u_map (
        .state      (ctrl_q.state),
        .mode       (ctrl_q.mode),
        .buf_ovr    (buf_ovr_i),
        .en_ldo     (en_ldo_o),
        .en_wut     (en_wut_o),
        .en_lbd     (en_lbd_o),
        .en_tmp     (en_tmp_o),
        .en_xtal    (en_xtal_o),
        .en_xbuf    (en_xbuf_o),
        .en_pll     (en_pll_o),
        .regs_valid (regs_valid_o),
        .spi_ok     (spi_ok_o)
    );

    assign mode_o = ctrl_q.state;   // R11
endmodule

// File: rtl/pm_ctrl_checker.sv
module pm_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_i,
    input logic       buf_ovr_i,
    input logic       en_ldo_o,
    input logic       en_xtal_o,
    input logic       en_xbuf_o,
    input logic       en_pll_o,
    input logic       regs_valid_o,
    input logic       spi_ok_o,
    input logic [2:0] mode_o
);
    assert_shdn_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_i |=> (mode_o == 3'd0 && !spi_ok_o && !en_ldo_o));

    assert_wake_por_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && !shdn_i) |=> (mode_o == 3'd1));

    assert_por_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (!regs_valid_o && spi_ok_o && !en_ldo_o && !en_xtal_o));

    assert_por_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && !shdn_i) |=> (mode_o == 3'd1 || mode_o == 3'd5));

    assert_xbuf_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_xbuf_o |-> (en_xtal_o && !buf_ovr_i));

    assert_tune_xtal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6) |-> (en_pll_o && en_xtal_o));

    assert_ovr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5 && buf_ovr_i && !shdn_i) |=> (mode_o >= 3'd5));
endmodule

bind radio_pwr_ctrl pm_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shdn_i       (shdn_i),
    .buf_ovr_i    (buf_ovr_i),
    .en_ldo_o     (en_ldo_o),
    .en_xtal_o    (en_xtal_o),
    .en_xbuf_o    (en_xbuf_o),
    .en_pll_o     (en_pll_o),
    .regs_valid_o (regs_valid_o),
    .spi_ok_o     (spi_ok_o),
    .mode_o       (mode_o)
);

// File: tb/radio_pwr_ctrl_bench.sv
module radio_pwr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int POR_N      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_i = 1'b0, swrst_i = 1'b0, mode_we_i = 1'b0;
    logic [7:0] mode_wdata_i = 8'h00;
    logic       irq_pend_i = 1'b0, irq_stat_rd_i = 1'b0, buf_ovr_i = 1'b0;
    logic       en_ldo_o, en_wut_o, en_lbd_o, en_tmp_o, en_xtal_o, en_xbuf_o, en_pll_o;
    logic       regs_valid_o, spi_ok_o;
    logic [2:0] mode_o;

    int checks = 0;
    int failures = 0;

    // model state: m_b = {wut, lbd, tmp, pll, xton}
    int       m_st;
    logic [4:0] m_b;
    int       m_cnt;
    bit       m_hold;
    bit       m_shq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    radio_pwr_ctrl #(.POR_CYCLES(POR_N)) u_radio_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .shdn_i(shdn_i), .swrst_i(swrst_i),
        .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
        .irq_pend_i(irq_pend_i), .irq_stat_rd_i(irq_stat_rd_i), .buf_ovr_i(buf_ovr_i),
        .en_ldo_o(en_ldo_o), .en_wut_o(en_wut_o), .en_lbd_o(en_lbd_o), .en_tmp_o(en_tmp_o),
        .en_xtal_o(en_xtal_o), .en_xbuf_o(en_xbuf_o), .en_pll_o(en_pll_o),
        .regs_valid_o(regs_valid_o), .spi_ok_o(spi_ok_o), .mode_o(mode_o)
    );

    function automatic int exp_target(logic [4:0] b, bit hold);
        if (b[1]) return 6;
        if (b[0] || hold) return 5;
        if (b[3] || b[2]) return 4;
        if (b[4]) return 3;
        return 2;
    endfunction

    function automatic logic [11:0] exp_out(int st, logic [4:0] b, bit bo);
        bit run = (st >= 2);
        bit xt  = (st >= 5);
        return {3'(st), run, run & b[4], run & b[3], run & b[2], xt, xt & !bo, st == 6, run, st != 0};
    endfunction

    function automatic logic [4:0] bits_of(logic [7:0] w);
        return {w[6], w[5], w[3], w[1], w[0]};
    endfunction

    task automatic check(string tag);
        logic [11:0] got, exp;
        got = {mode_o, en_ldo_o, en_wut_o, en_lbd_o, en_tmp_o, en_xtal_o, en_xbuf_o,
               en_pll_o, regs_valid_o, spi_ok_o};
        exp = exp_out(m_st, m_b, buf_ovr_i);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%03h expected=%03h (mode %0d vs %0d)", tag, got, exp, mode_o, m_st);
        end
    endtask

    task automatic step(string tag, bit sh, bit sw, bit we, logic [7:0] wd, bit pd, bit rd, bit bo);
        logic [4:0] nb;
        int tg;
        shdn_i = sh; swrst_i = sw; mode_we_i = we; mode_wdata_i = wd;
        irq_pend_i = pd; irq_stat_rd_i = rd; buf_ovr_i = bo;
        if (sh) begin
            m_st = 0;
        end else if (m_shq || m_st == 0) begin
            m_st = 1; m_cnt = POR_N - 1;
        end else if (m_st == 1) begin
            if (m_cnt == 0) begin
                m_st = 5; m_b = 5'b00001; m_hold = 1'b1;
            end else begin
                m_cnt--;
            end
        end else begin
            nb = sw ? 5'b00001 : (we ? bits_of(wd) : m_b);
            tg = exp_target(nb, m_hold);
            m_b = nb;
            m_st = (m_st == 5 && bo && tg < 5) ? 5 : tg;
            if (rd) m_hold = 1'b0;
            else if (pd) m_hold = 1'b1;
        end
        m_shq = sh;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    function automatic string tag_of(int st);
        case (st)
            0: return "R1";
            1: return "R2";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_st = 1; m_b = 5'b00001; m_cnt = POR_N - 1; m_hold = 1'b1; m_shq = 1'b0;
        void'($urandom(32'h00C0FFEE));
        @(negedge clk);
        @(negedge clk);
        check("R2 reset state");
        rst_n = 1'b1;

        // power-on sequence then READY (R2, R3)
        for (int i = 0; i < POR_N + 1; i++) step("R3 power-on to READY", 0, 0, 0, 8'h00, 0, 0, 0);

        // R9: latched interrupt after POR holds READY until read
        step("R9 standby held by irq", 0, 0, 1, 8'h00, 0, 0, 0);
        step("R9 status read", 0, 0, 0, 8'h00, 0, 1, 0);
        step("R5 standby", 0, 0, 0, 8'h00, 0, 0, 0);

        step("R6 sleep", 0, 0, 1, 8'h40, 0, 0, 0);
        step("R6 sensor both", 0, 0, 1, 8'h28, 0, 0, 0);
        step("R6 sensor lbd", 0, 0, 1, 8'h20, 0, 0, 0);
        step("R6 sensor with wut", 0, 0, 1, 8'h48, 0, 0, 0);

        step("R7 ready buffer off", 0, 0, 1, 8'h01, 0, 0, 1);
        step("R10 held by override", 0, 0, 1, 8'h00, 0, 0, 1);
        step("R10 still held", 0, 0, 0, 8'h00, 0, 0, 1);
        step("R10 released", 0, 0, 0, 8'h00, 0, 0, 0);

        step("R8 tune no xton", 0, 0, 1, 8'h02, 0, 0, 0);
        step("R8 tune cumulative", 0, 0, 1, 8'h43, 0, 0, 1);
        step("R4 reserved bits ignored", 0, 0, 1, 8'h94, 0, 0, 0);
        step("R4 priority all bits", 0, 0, 1, 8'h6B, 0, 0, 0);
        step("R4 ready beats sensor", 0, 0, 1, 8'h69, 0, 0, 0);

        step("R5 back to standby", 0, 0, 1, 8'h00, 0, 0, 0);
        step("R9 pending sampled", 0, 0, 0, 8'h00, 1, 0, 0);
        step("R9 held ready", 0, 0, 0, 8'h00, 0, 0, 0);
        step("R9 read wins over pend", 0, 0, 0, 8'h00, 1, 1, 0);
        step("R9 standby after read", 0, 0, 0, 8'h00, 0, 0, 0);

        step("R6 sleep before swrst", 0, 0, 1, 8'h40, 0, 0, 0);
        step("R3 swrst beats write", 0, 1, 1, 8'h40, 0, 0, 0);

        step("R1 shutdown", 1, 0, 0, 8'h00, 0, 0, 0);
        step("R1 write ignored", 1, 0, 1, 8'h02, 0, 0, 0);
        step("R1 swrst ignored", 1, 1, 0, 8'h00, 0, 0, 0);
        step("R11 por code", 0, 0, 1, 8'h02, 0, 0, 0);
        for (int i = 0; i < POR_N; i++) step("R2 writes ignored in por", 0, 0, 1, 8'h02, 0, 0, 0);
        step("R3 ready after shutdown", 0, 0, 0, 8'h00, 0, 0, 0);

        for (int i = 0; i < 6000; i++) begin
            bit sh, sw, we, pd, rd, bo;
            logic [7:0] wd;
            sh = ($urandom % 150) == 0;
            sw = ($urandom % 60) == 0;
            we = ($urandom % 3) == 0;
            wd = 8'($urandom);
            if ($urandom % 3 == 0) wd = wd & 8'h68;
            pd = ($urandom % 25) == 0;
            rd = ($urandom % 6) == 0;
            bo = ($urandom % 4) == 0;
            step(tag_of(m_st), sh, sw, we, wd, pd, rd, bo);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule